// File: doc/BRIEF.md
# Protected Array Read Address Generator

This block produces the byte address used while streaming reads out of one of two password-protected arrays inside an authorized session. Array 0 is a 13-bit (8192-byte) space. Array 1 is a 5-bit (32-byte) space. Once the session opens, the host supplies a two-byte start address. The block then advances that address by one for every read byte the master acknowledges, and wraps at the top of whichever array is selected.

Inside the same session the host can re-aim a read with a repeated start followed by one new address byte. On array 0 that byte replaces only the low eight bits, so random access stays inside the current 256-byte block. On array 1 the byte covers the whole space. A not-acknowledged byte freezes the address until a repeated start or a stop. A stop closes the session, clears the address and raises a one-cycle end indication. The surrounding logic (bus framing, password checking and storage) drives the strobes and consumes the address.

Top module: `prot_rd_addr_gen`

## Requirements
- R1: After reset, `addr` is zero and `sess_end` is low.
- R2: On array 0, the first `addr_stb` byte of a session sets address bits 12:8 and the second sets bits 7:0. Bits of the first byte above bit 4 are ignored.
- R3: On array 1, the first address byte is ignored entirely, and of the second byte only bits 4:0 are kept.
- R4: Each cycle with `byte_done` and `byte_ack` both high in the streaming phase adds one to the address. On array 0 this carries across 256-byte blocks and wraps from 0x1FFF to 0x0000.
- R5: On array 1, the sequential increment wraps from 0x1F to 0x00.
- R6: A `byte_done` with `byte_ack` low stops the address. Later acknowledged bytes leave it unchanged until a repeated start or a stop.
- R7: After `rstart`, the next `addr_stb` byte on array 0 replaces bits 7:0 and keeps bits 12:8 unchanged.
- R8: After `rstart`, the next `addr_stb` byte on array 1 sets the whole 5-bit address from its bits 4:0.
- R9: When `sess_act` falls (stop), the address becomes zero. `sess_end` is high for exactly the one following cycle.
- R10: While `sess_act` is low, address strobes, acknowledges and repeated starts have no effect, and `addr` stays zero.
- R11: `arr_sel` is sampled once, in the first clock after `sess_act` rises (0 = array 0, 1 = array 1). Later changes within the session are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sess_act | input | 1 | High while an authorized session is open; its fall marks the stop |
| arr_sel | input | 1 | Array choice, sampled at session open (0 = array 0, 1 = array 1) |
| addr_stb | input | 1 | One-cycle strobe: `addr_byte` carries an address byte |
| addr_byte | input | 8 | Address byte value |
| byte_done | input | 1 | One-cycle strobe: a read byte has finished its acknowledge slot |
| byte_ack | input | 1 | Acknowledge value for the byte finished by `byte_done` |
| rstart | input | 1 | One-cycle strobe: repeated start seen inside the session |
| addr | output | 13 | Current read address |
| sess_end | output | 1 | One-cycle pulse after the session closes |

## Verification
The checker assumes that `addr_stb`, `byte_done` and `rstart` are single-cycle strobes that never coincide. It also assumes that `arr_sel` is settled during the first cycle of `sess_act`. Its increment and hold properties are conditioned on `sess_act` staying high and on no repeated start in the same cycle. The bench drives every strobe on a falling clock edge, one cycle at a time. It never overlaps two strobes, and it changes `arr_sel` only outside that opening cycle, including once on purpose mid-session to show the sample is held.

// File: rtl/rdag_pkg.sv
package rdag_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HI,
      ST_LO,
      ST_RUN,
      ST_RND,
      ST_HOLD
   } rdag_st_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_CLR,
      OP_HI,
      OP_LO,
      OP_RND,
      OP_INC
   } rdag_op_e;
endpackage

// File: rtl/rdag_ctrl.sv
module rdag_ctrl
   import rdag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sess_act,
   input  logic     arr_sel,
   input  logic     addr_stb,
   input  logic     byte_done,
   input  logic     byte_ack,
   input  logic     rstart,
   output rdag_st_e st,
   output rdag_op_e op,
   output logic     arr_q,
   output logic     sess_end
);
   logic act_q;

   // R11: array choice captured once when the session opens
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         arr_q    <= 1'b0;
         act_q    <= 1'b0;
         sess_end <= 1'b0;
      end else begin
         act_q    <= sess_act;
         sess_end <= act_q & ~sess_act;
         if (!sess_act) begin
            st <= ST_IDLE;
         end else begin
            unique case (st)
               ST_IDLE: begin
                  st    <= ST_HI;
                  arr_q <= arr_sel;
               end
               ST_HI:   if (addr_stb) st <= ST_LO;
               ST_LO:   if (addr_stb) st <= ST_RUN;
               ST_RUN: begin
                  if (rstart)
                     st <= ST_RND;
                  else if (byte_done && !byte_ack)
                     st <= ST_HOLD;
               end
               ST_RND:  if (addr_stb) st <= ST_RUN;
               ST_HOLD: if (rstart) st <= ST_RND;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      op = OP_NONE;
      if (!sess_act) begin
         op = OP_CLR;
      end else begin
         unique case (st)
            ST_HI:   if (addr_stb) op = OP_HI;
            ST_LO:   if (addr_stb) op = OP_LO;
            ST_RUN:  if (!rstart && byte_done && byte_ack) op = OP_INC;
            ST_RND:  if (addr_stb) op = OP_RND;
            default: op = OP_NONE;
         endcase
      end
   end
endmodule

// File: rtl/rdag_addr.sv
module rdag_addr
   import rdag_pkg::*;
#(
   parameter int A0_AW = 13,
   parameter int A1_AW = 5,
   parameter int BW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rdag_op_e         op,
   input  logic             arr,
   input  logic [BW-1:0]    byte_in,
   output logic [A0_AW-1:0] addr_q
);
   localparam int AW = A0_AW;
   localparam logic [AW-1:0] M0 = '1;
   localparam logic [AW-1:0] M1 = AW'((64'd1 << A1_AW) - 64'd1);

   logic [AW-1:0] mask;
   logic [AW-1:0] ld_hi;
   logic [AW-1:0] ld_low;
   logic [AW-1:0] nxt;

   assign mask = arr ? M1 : M0;

   // R2/R3: high byte lands above the low byte, then the array mask drops spare bits
   assign ld_hi  = AW'({byte_in, addr_q[BW-1:0]}) & mask;
   // R7/R8: low or random byte keeps the current upper field, masked per array
   assign ld_low = {addr_q[AW-1:BW], byte_in} & mask;

   always_comb begin
      unique case (op)
         OP_CLR:  nxt = '0;
         OP_HI:   nxt = ld_hi;
         OP_LO:   nxt = ld_low;
         OP_RND:  nxt = ld_low;
         OP_INC:  nxt = (addr_q + AW'(1)) & mask;
         default: nxt = addr_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= nxt;
   end
endmodule

// File: rtl/prot_rd_addr_gen.sv
module prot_rd_addr_gen
   import rdag_pkg::*;
#(
   parameter int A0_AW = 13,
   parameter int A1_AW = 5,
   parameter int BW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sess_act,
   input  logic             arr_sel,
   input  logic             addr_stb,
   input  logic [BW-1:0]    addr_byte,
   input  logic             byte_done,
   input  logic             byte_ack,
   input  logic             rstart,
   output logic [A0_AW-1:0] addr,
   output logic             sess_end
);
   generate
      if (A0_AW <= BW || A0_AW > 2 * BW)
         $error("A0_AW must lie between BW+1 and 2*BW");
      if (A1_AW < 1 || A1_AW > BW)
         $error("A1_AW must lie between 1 and BW");
   endgenerate

   rdag_st_e st_w;
   rdag_op_e op_w;
   logic     arr_w;

   rdag_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sess_act  (sess_act),
      .arr_sel   (arr_sel),
      .addr_stb  (addr_stb),
      .byte_done (byte_done),
      .byte_ack  (byte_ack),
      .rstart    (rstart),
      .st        (st_w),
      .op        (op_w),
      .arr_q     (arr_w),
      .sess_end  (sess_end)
   );

   rdag_addr #(.A0_AW(A0_AW), .A1_AW(A1_AW), .BW(BW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op_w),
      .arr     (arr_w),
      .byte_in (addr_byte),
      .addr_q  (addr)
   );
endmodule

// File: rtl/rdag_chk.sv
module rdag_chk
   import rdag_pkg::*;
#(
   parameter int A0_AW = 13,
   parameter int A1_AW = 5,
   parameter int BW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sess_act,
   input logic             addr_stb,
   input logic             byte_done,
   input logic             byte_ack,
   input logic             rstart,
   input logic [A0_AW-1:0] addr,
   input logic             sess_end,
   input rdag_st_e         st,
   input logic             arr_q
);
   localparam int AW = A0_AW;
   localparam logic [AW-1:0] M0 = '1;
   localparam logic [AW-1:0] M1 = AW'((64'd1 << A1_AW) - 64'd1);

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sess_act |=> addr == '0);

   // R9
   end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sess_act) |=> sess_end);

   // R9
   end_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sess_end |=> !sess_end);

   // R3
   a1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_q |-> (addr & ~M1) == '0);

   // R4
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sess_act && byte_done && byte_ack && !rstart)
      |=> addr == (($past(addr) + AW'(1)) & (arr_q ? M1 : M0)));

   // R6
   nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && sess_act && !rstart) |=> $stable(addr));

   // R7
   rnd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RND && !arr_q && sess_act && addr_stb)
      |=> addr[AW-1:BW] == $past(addr[AW-1:BW]));
endmodule

bind prot_rd_addr_gen rdag_chk #(.A0_AW(A0_AW), .A1_AW(A1_AW), .BW(BW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sess_act  (sess_act),
   .addr_stb  (addr_stb),
   .byte_done (byte_done),
   .byte_ack  (byte_ack),
   .rstart    (rstart),
   .addr      (addr),
   .sess_end  (sess_end),
   .st        (st_w),
   .arr_q     (arr_w)
);

// File: tb/prot_rd_addr_gen_tb.sv
`timescale 1ns/1ps
module prot_rd_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sess_act = 1'b0;
   logic        arr_sel = 1'b0;
   logic        addr_stb = 1'b0;
   logic [7:0]  addr_byte = 8'h00;
   logic        byte_done = 1'b0;
   logic        byte_ack = 1'b0;
   logic        rstart = 1'b0;
   logic [12:0] addr;
   logic        sess_end;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   prot_rd_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .sess_act(sess_act), .arr_sel(arr_sel),
      .addr_stb(addr_stb), .addr_byte(addr_byte), .byte_done(byte_done),
      .byte_ack(byte_ack), .rstart(rstart), .addr(addr), .sess_end(sess_end)
   );

   // {array, high byte, low byte, acked bytes, expected address}
   localparam logic [40:0] VEC [7] = '{
      {1'b0, 8'h00, 8'h00, 8'd3, 16'h0003},
      {1'b0, 8'h1F, 8'hFE, 8'd3, 16'h0001},
      {1'b0, 8'hFF, 8'hFF, 8'd1, 16'h0000},
      {1'b1, 8'h12, 8'h3E, 8'd1, 16'h001F},
      {1'b1, 8'h00, 8'h1F, 8'd2, 16'h0001},
      {1'b0, 8'h0A, 8'h80, 8'd5, 16'h0A85},
      {1'b1, 8'hFF, 8'hFF, 8'd0, 16'h001F}
   };

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic open_sess(input logic a);
      arr_sel  = a;
      sess_act = 1'b1;
      @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      addr_byte = b;
      addr_stb  = 1'b1;
      @(negedge clk);
      addr_stb  = 1'b0;
   endtask

   task automatic acks(input int n);
      for (int k = 0; k < n; k++) begin
         byte_done = 1'b1;
         byte_ack  = 1'b1;
         @(negedge clk);
      end
      byte_done = 1'b0;
      byte_ack  = 1'b0;
   endtask

   task automatic nack();
      byte_done = 1'b1;
      byte_ack  = 1'b0;
      @(negedge clk);
      byte_done = 1'b0;
   endtask

   task automatic rs();
      rstart = 1'b1;
      @(negedge clk);
      rstart = 1'b0;
   endtask

   task automatic stop_chk(input string tag);
      sess_act = 1'b0;
      @(negedge clk);
      chk({tag, " R9 addr cleared"}, {3'b0, addr}, 16'h0000);
      chk({tag, " R9 end pulse"}, {15'b0, sess_end}, 16'h0001);
      @(negedge clk);
      chk({tag, " R9 end pulse width"}, {15'b0, sess_end}, 16'h0000);
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset addr", {3'b0, addr}, 16'h0000);
      chk("R1 reset sess_end", {15'b0, sess_end}, 16'h0000);

      // R2 R3 R4 R5: load, stream and wrap vectors
      for (int i = 0; i < 7; i++) begin
         logic [40:0] v;
         v = VEC[i];
         open_sess(v[40]);
         put(v[39:32]);
         put(v[31:24]);
         acks(int'(v[23:16]));
         chk($sformatf("R2/R3/R4/R5 vector %0d", i), {3'b0, addr}, v[15:0]);
         stop_chk($sformatf("vector %0d", i));
      end

      // R6 R7 R4: array 0 nack hold, random re-address, block carry
      open_sess(1'b0);
      put(8'h0A);
      put(8'h80);
      acks(2);
      chk("R4 array0 stream", {3'b0, addr}, 16'h0A82);
      nack();
      chk("R6 nack holds", {3'b0, addr}, 16'h0A82);
      acks(2);
      chk("R6 ack after nack ignored", {3'b0, addr}, 16'h0A82);
      rs();
      put(8'h15);
      chk("R7 random keeps upper bits", {3'b0, addr}, 16'h0A15);
      acks(1);
      chk("R4 stream after random", {3'b0, addr}, 16'h0A16);
      rs();
      put(8'hFF);
      chk("R7 random to block top", {3'b0, addr}, 16'h0AFF);
      acks(1);
      chk("R4 carry into next block", {3'b0, addr}, 16'h0B00);
      stop_chk("r7_session");

      // R8 R5: array 1 random reaches whole space
      open_sess(1'b1);
      put(8'h00);
      put(8'h05);
      chk("R3 array1 load", {3'b0, addr}, 16'h0005);
      rs();
      put(8'hFE);
      chk("R8 array1 random masked", {3'b0, addr}, 16'h001E);
      acks(2);
      chk("R5 array1 wrap after random", {3'b0, addr}, 16'h0000);
      stop_chk("r8_session");

      // R11: array select change mid-session ignored
      open_sess(1'b1);
      put(8'h00);
      put(8'h1F);
      arr_sel = 1'b0;
      acks(1);
      chk("R11 array held at open", {3'b0, addr}, 16'h0000);
      stop_chk("r11_session");

      // R10: strobes outside a session do nothing
      addr_byte = 8'h55;
      addr_stb  = 1'b1;
      @(negedge clk);
      addr_stb  = 1'b0;
      acks(3);
      rs();
      chk("R10 idle addr", {3'b0, addr}, 16'h0000);
      chk("R10 idle sess_end", {15'b0, sess_end}, 16'h0000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule